// File: doc/BRIEF.md
# Instruction Address Sequencer with Single-Entry Return Stack

This block picks the program-memory address for a small 8-bit controller that holds 1024 words of 14-bit code. Each clock is one instruction cycle. The fetch of one word overlaps with the execution of the word before it. The decoder tells the block, through one-hot strobes, what the executing instruction does to the flow of control:
- a plain step,
- a conditional skip,
- a write to the low address byte,
- an absolute jump,
- a call,
- a return,
- a table lookup.

The block then drives the next address, saves or restores a single return address, and raises a flush pulse when the word that is already fetched must be thrown away.

Any change of flow costs one extra cycle. A jump, call, return, low-byte write or taken skip flushes the prefetched word, and the following cycle is a dummy slot in which decoder strobes are ignored. A table lookup borrows the memory port for one cycle. In that cycle the low address byte comes from a table pointer and the page comes either from the current fetch page or from the last page. The low byte of the returned word is handed out at once. The upper bits are latched into a read-only high-byte register whose two top bits read as zero. Fetching then resumes where it stopped.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `rom_addr` is 000h, `slot_vld` is 1, `flush` is 0, `rom_is_tbl` is 0 and `tbl_hi` is 00h. The return entry is cleared to 000h.
- R2: In an executing slot with no flow strobe, the next cycle's `rom_addr` is the current one plus one, wrapping from 3FFh to 000h.
- R3: A low-byte write loads `rom_addr[7:0]` with `pcl_wdata` and keeps `rom_addr[9:8]`. `pcl_rdata` always shows the low byte of the current fetch address.
- R4: A jump loads all 10 bits of the next `rom_addr` from `imm_tgt`.
- R5: A call stores the current `rom_addr` (the address of the word after the call) as the return entry and jumps to `imm_tgt`. A second call replaces the stored entry.
- R6: A return loads the next `rom_addr` from the return entry. The entry keeps its value, so a return with no call since reset goes to 000h.
- R7: A skip strobe with `skip_cond`=1 raises `flush`, and fetching continues at the current address plus one. With `skip_cond`=0 the skip strobe has no effect.
- R8: `flush` is high only in the cycle where a flow change executes. In the next cycle `slot_vld` is 0, all strobes are ignored, and the address advances by one.
- R9: A table strobe makes the next cycle a table cycle with `rom_is_tbl`=1 and `slot_vld`=0, and does not raise `flush`. In that cycle `rom_addr` is {page, `tbl_ptr`}. The page is the current `rom_addr[9:8]` for `ex_tbl_cur` and 11b for `ex_tbl_last`. The cycle after that fetches the address following the one fetched when the strobe was given.
- R10: In the table cycle, `tbl_lo` equals `rom_word[7:0]` and `tbl_lo_vld` is 1. At the end of that cycle `tbl_hi` becomes {00b, `rom_word[13:8]`}. `tbl_hi` keeps its value at all other times.
- R11: When several strobes are given together, the first one in this order wins: return, call, jump, low-byte write, taken skip, table lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ex_jmp | input | 1 | Executing word is an absolute jump |
| ex_call | input | 1 | Executing word is a call |
| ex_ret | input | 1 | Executing word is a return |
| ex_pcl_wr | input | 1 | Executing word writes the low address byte |
| ex_skip_op | input | 1 | Executing word is a conditional skip |
| skip_cond | input | 1 | Skip condition is true |
| ex_tbl_cur | input | 1 | Table lookup in the current page |
| ex_tbl_last | input | 1 | Table lookup in the last page |
| imm_tgt | input | 10 | Jump or call target from the instruction |
| pcl_wdata | input | 8 | Data written to the low address byte |
| tbl_ptr | input | 8 | Table pointer (low address byte of a lookup) |
| rom_word | input | 14 | Program memory word for the current `rom_addr` |
| rom_addr | output | 10 | Program memory address |
| rom_is_tbl | output | 1 | Current `rom_addr` is a table lookup address |
| slot_vld | output | 1 | Execution slot holds a real instruction |
| flush | output | 1 | Prefetched word is discarded |
| pcl_rdata | output | 8 | Readable low byte of the fetch address |
| tbl_lo | output | 8 | Low byte of the looked-up word |
| tbl_lo_vld | output | 1 | `tbl_lo` is valid |
| tbl_hi | output | 8 | Read-only high byte of the last lookup |

## Verification
The address sequencing is driven with a cycle table that runs, in turn:
- plain steps, including the wrap at 3FFh;
- a jump, a call and a return, whose correct targets separate the immediate, stack and increment sources;
- a taken and an untaken skip, which separate a flush with a +1 continuation from no effect at all;
- a low-byte write from a non-zero page, which shows that the page bits are kept;
- a jump strobe given during a dummy slot, which shows whether strobes are really ignored there.

Combined strobes (call with return, jump with low-byte write, taken skip with table lookup) pin down the priority order. Lookups in the current page and in the last page, each with a distinct word, separate the two page sources and the low-byte and high-byte paths. Back-to-back calls followed by two returns show that the entry is overwritten and then kept.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    SLOT_RUN   = 2'd0,
    SLOT_DUMMY = 2'd1,
    SLOT_TBL   = 2'd2
  } slot_e;

  typedef enum logic [2:0] {
    NX_INC  = 3'd0,
    NX_HOLD = 3'd1,
    NX_PCL  = 3'd2,
    NX_IMM  = 3'd3,
    NX_STK  = 3'd4
  } nx_sel_e;

  typedef struct packed {
    logic jmp;
    logic call;
    logic ret;
    logic pcl_wr;
    logic skip_op;
    logic skip_cond;
    logic tbl_cur;
    logic tbl_last;
  } ex_ctl_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ex_ctl_t ctl,
  output nx_sel_e nx_sel,
  output logic    push,
  output logic    flush,
  output logic    slot_vld,
  output logic    in_tbl,
  output logic    tbl_last_q
);

  slot_e st_q, st_d;
  logic  last_q, last_d, last_en;

  always_comb begin
    st_d    = SLOT_RUN;
    nx_sel  = NX_INC;
    push    = 1'b0;
    flush   = 1'b0;
    last_en = 1'b0;
    last_d  = last_q;
    case (st_q)
      SLOT_DUMMY: nx_sel = NX_INC;
      SLOT_TBL:   nx_sel = NX_INC;
      default: begin
        if (ctl.ret) begin
          nx_sel = NX_STK;
          flush  = 1'b1;
          st_d   = SLOT_DUMMY;
        end else if (ctl.call) begin
          nx_sel = NX_IMM;
          push   = 1'b1;
          flush  = 1'b1;
          st_d   = SLOT_DUMMY;
        end else if (ctl.jmp) begin
          nx_sel = NX_IMM;
          flush  = 1'b1;
          st_d   = SLOT_DUMMY;
        end else if (ctl.pcl_wr) begin
          nx_sel = NX_PCL;
          flush  = 1'b1;
          st_d   = SLOT_DUMMY;
        end else if (ctl.skip_op && ctl.skip_cond) begin
          nx_sel = NX_INC;
          flush  = 1'b1;
          st_d   = SLOT_DUMMY;
        end else if (ctl.tbl_cur || ctl.tbl_last) begin
          nx_sel  = NX_HOLD;
          st_d    = SLOT_TBL;
          last_en = 1'b1;
          last_d  = ctl.tbl_last && !ctl.tbl_cur;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_RUN;
      last_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (last_en) begin
        last_q <= last_d;
      end
    end
  end

  assign slot_vld   = (st_q == SLOT_RUN);
  assign in_tbl     = (st_q == SLOT_TBL);
  assign tbl_last_q = last_q;

  // R8
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R8
  dummy_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot_vld);

  // R9
  tbl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_tbl |=> slot_vld);

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] entry
);

  logic [ADDR_W-1:0] ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (push) begin
      ent_q <= push_addr;
    end
  end

  assign entry = ent_q;

endmodule

// File: rtl/pcseq_tbl.sv
module pcseq_tbl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int WORD_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_tbl,
  input  logic                     last_sel,
  input  logic [ADDR_W-DATA_W-1:0] page_cur,
  input  logic [DATA_W-1:0]        ptr,
  input  logic [WORD_W-1:0]        rom_word,
  output logic [ADDR_W-1:0]        tbl_addr,
  output logic [DATA_W-1:0]        tbl_lo,
  output logic                     tbl_lo_vld,
  output logic [DATA_W-1:0]        tbl_hi
);

  localparam int PG_W  = ADDR_W - DATA_W;
  localparam int TH_W  = WORD_W - DATA_W;
  localparam int PAD_W = DATA_W - TH_W;

  logic [PG_W-1:0]   page;
  logic [DATA_W-1:0] hi_d, hi_q;

  assign page     = last_sel ? {PG_W{1'b1}} : page_cur;
  assign tbl_addr = {page, ptr};
  assign tbl_lo     = rom_word[DATA_W-1:0];
  assign tbl_lo_vld = in_tbl;

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_d = {{PAD_W{1'b0}}, rom_word[WORD_W-1:DATA_W]};
    end else begin : g_nopad
      assign hi_d = rom_word[WORD_W-1:DATA_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (in_tbl) begin
      hi_q <= hi_d;
    end
  end

  assign tbl_hi = hi_q;

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_jmp,
  input  logic              ex_call,
  input  logic              ex_ret,
  input  logic              ex_pcl_wr,
  input  logic              ex_skip_op,
  input  logic              skip_cond,
  input  logic              ex_tbl_cur,
  input  logic              ex_tbl_last,
  input  logic [ADDR_W-1:0] imm_tgt,
  input  logic [DATA_W-1:0] pcl_wdata,
  input  logic [DATA_W-1:0] tbl_ptr,
  input  logic [WORD_W-1:0] rom_word,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_is_tbl,
  output logic              slot_vld,
  output logic              flush,
  output logic [DATA_W-1:0] pcl_rdata,
  output logic [DATA_W-1:0] tbl_lo,
  output logic              tbl_lo_vld,
  output logic [DATA_W-1:0] tbl_hi
);

  localparam int PG_W = ADDR_W - DATA_W;

  logic [1:0]        rst_sync;
  logic              rst_i;
  ex_ctl_t           ctl;
  nx_sel_e           nx_sel;
  logic              push, in_tbl, last_sel;
  logic [ADDR_W-1:0] pc_q, pc_d, stk_ent, tbl_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i = rst_sync[1];

  always_comb begin
    ctl.jmp       = ex_jmp;
    ctl.call      = ex_call;
    ctl.ret       = ex_ret;
    ctl.pcl_wr    = ex_pcl_wr;
    ctl.skip_op   = ex_skip_op;
    ctl.skip_cond = skip_cond;
    ctl.tbl_cur   = ex_tbl_cur;
    ctl.tbl_last  = ex_tbl_last;
  end

  pcseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .ctl        (ctl),
    .nx_sel     (nx_sel),
    .push       (push),
    .flush      (flush),
    .slot_vld   (slot_vld),
    .in_tbl     (in_tbl),
    .tbl_last_q (last_sel)
  );

  pcseq_stack #(.ADDR_W(ADDR_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_i),
    .push      (push),
    .push_addr (pc_q),
    .entry     (stk_ent)
  );

  pcseq_tbl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_i),
    .in_tbl     (in_tbl),
    .last_sel   (last_sel),
    .page_cur   (pc_q[ADDR_W-1:DATA_W]),
    .ptr        (tbl_ptr),
    .rom_word   (rom_word),
    .tbl_addr   (tbl_addr),
    .tbl_lo     (tbl_lo),
    .tbl_lo_vld (tbl_lo_vld),
    .tbl_hi     (tbl_hi)
  );

  always_comb begin
    case (nx_sel)
      NX_HOLD: pc_d = pc_q;
      NX_PCL:  pc_d = {pc_q[ADDR_W-1:DATA_W], pcl_wdata};
      NX_IMM:  pc_d = imm_tgt;
      NX_STK:  pc_d = stk_ent;
      default: pc_d = pc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign rom_addr   = in_tbl ? tbl_addr : pc_q;
  assign rom_is_tbl = in_tbl;
  assign pcl_rdata  = pc_q[DATA_W-1:0];

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (slot_vld && !flush && !ex_tbl_cur && !ex_tbl_last)
      |=> rom_addr == $past(rom_addr) + 1'b1);

  // R8
  dummy_inc_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!slot_vld && !rom_is_tbl) |=> rom_addr == $past(rom_addr) + 1'b1);

  // R3
  pcl_page_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (slot_vld && ex_pcl_wr && !ex_ret && !ex_call && !ex_jmp)
      |=> rom_addr == {$past(rom_addr[ADDR_W-1:DATA_W]), $past(pcl_wdata)});

  // R4
  jmp_tgt_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (slot_vld && ex_jmp && !ex_ret && !ex_call) |=> rom_addr == $past(imm_tgt));

  // R6
  ret_tgt_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (slot_vld && ex_ret) |=> rom_addr == $past(stk_ent));

  // R9
  tbl_noflush_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rom_is_tbl |-> (!slot_vld && !flush && tbl_lo_vld));

  // R9
  tbl_page_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rom_is_tbl |-> (last_sel ? (rom_addr[ADDR_W-1:DATA_W] == {PG_W{1'b1}})
                             : (rom_addr[ADDR_W-1:DATA_W] == pc_q[ADDR_W-1:DATA_W])));

endmodule

// File: tb/pcseq_top_tb_top.sv
module pcseq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ex_jmp, ex_call, ex_ret, ex_pcl_wr, ex_skip_op, skip_cond;
  logic        ex_tbl_cur, ex_tbl_last;
  logic [9:0]  imm_tgt;
  logic [7:0]  pcl_wdata, tbl_ptr;
  logic [13:0] rom_word;
  logic [9:0]  rom_addr;
  logic        rom_is_tbl, slot_vld, flush, tbl_lo_vld;
  logic [7:0]  pcl_rdata, tbl_lo, tbl_hi;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .ex_jmp(ex_jmp), .ex_call(ex_call), .ex_ret(ex_ret),
    .ex_pcl_wr(ex_pcl_wr), .ex_skip_op(ex_skip_op), .skip_cond(skip_cond),
    .ex_tbl_cur(ex_tbl_cur), .ex_tbl_last(ex_tbl_last), .imm_tgt(imm_tgt),
    .pcl_wdata(pcl_wdata), .tbl_ptr(tbl_ptr), .rom_word(rom_word),
    .rom_addr(rom_addr), .rom_is_tbl(rom_is_tbl), .slot_vld(slot_vld),
    .flush(flush), .pcl_rdata(pcl_rdata), .tbl_lo(tbl_lo),
    .tbl_lo_vld(tbl_lo_vld), .tbl_hi(tbl_hi)
  );

  // control code bits: jmp call ret pcl skip_op skip_cond tbl_cur tbl_last
  localparam logic [7:0] C_N  = 8'h00;
  localparam logic [7:0] C_J  = 8'h80;
  localparam logic [7:0] C_C  = 8'h40;
  localparam logic [7:0] C_R  = 8'h20;
  localparam logic [7:0] C_P  = 8'h10;
  localparam logic [7:0] C_SK = 8'h08;
  localparam logic [7:0] C_SC = 8'h04;
  localparam logic [7:0] C_TC = 8'h02;
  localparam logic [7:0] C_TL = 8'h01;

  // {ctl, imm, wdata, expected rom_addr, expected flush, expected slot_vld, req}
  localparam int NV = 25;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {C_N,       10'h000, 8'h00, 10'h000, 1'b0, 1'b1, 4'd2},  // R2
    {C_N,       10'h000, 8'h00, 10'h001, 1'b0, 1'b1, 4'd2},  // R2
    {C_J,       10'h155, 8'h00, 10'h002, 1'b1, 1'b1, 4'd4},  // R4
    {C_J,       10'h3AA, 8'h00, 10'h155, 1'b0, 1'b0, 4'd8},  // R8 ignored jump
    {C_N,       10'h000, 8'h00, 10'h156, 1'b0, 1'b1, 4'd4},  // R4
    {C_C,       10'h200, 8'h00, 10'h157, 1'b1, 1'b1, 4'd5},  // R5
    {C_N,       10'h000, 8'h00, 10'h200, 1'b0, 1'b0, 4'd5},  // R5
    {C_N,       10'h000, 8'h00, 10'h201, 1'b0, 1'b1, 4'd5},  // R5
    {C_R,       10'h000, 8'h00, 10'h202, 1'b1, 1'b1, 4'd6},  // R6
    {C_N,       10'h000, 8'h00, 10'h157, 1'b0, 1'b0, 4'd6},  // R6
    {C_SK|C_SC, 10'h000, 8'h00, 10'h158, 1'b1, 1'b1, 4'd7},  // R7 taken
    {C_N,       10'h000, 8'h00, 10'h159, 1'b0, 1'b0, 4'd7},  // R7
    {C_SK,      10'h000, 8'h00, 10'h15A, 1'b0, 1'b1, 4'd7},  // R7 not taken
    {C_P,       10'h000, 8'h10, 10'h15B, 1'b1, 1'b1, 4'd3},  // R3
    {C_N,       10'h000, 8'h00, 10'h110, 1'b0, 1'b0, 4'd3},  // R3 page kept
    {C_N,       10'h000, 8'h00, 10'h111, 1'b0, 1'b1, 4'd3},  // R3
    {C_C|C_R,   10'h3C0, 8'h00, 10'h112, 1'b1, 1'b1, 4'd11}, // R11 return wins
    {C_N,       10'h000, 8'h00, 10'h157, 1'b0, 1'b0, 4'd11}, // R11
    {C_C,       10'h3FE, 8'h00, 10'h158, 1'b1, 1'b1, 4'd5},  // R5
    {C_N,       10'h000, 8'h00, 10'h3FE, 1'b0, 1'b0, 4'd5},  // R5
    {C_N,       10'h000, 8'h00, 10'h3FF, 1'b0, 1'b1, 4'd2},  // R2
    {C_N,       10'h000, 8'h00, 10'h000, 1'b0, 1'b1, 4'd2},  // R2 wrap
    {C_J|C_P,   10'h0F0, 8'h55, 10'h001, 1'b1, 1'b1, 4'd11}, // R11 jump wins
    {C_N,       10'h000, 8'h00, 10'h0F0, 1'b0, 1'b0, 4'd11}, // R11
    {C_N,       10'h000, 8'h00, 10'h0F1, 1'b0, 1'b1, 4'd2}   // R2
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic [9:0] imm, input logic [7:0] wd,
                       input logic [7:0] ptr, input logic [13:0] word);
    @(negedge clk);
    {ex_jmp, ex_call, ex_ret, ex_pcl_wr, ex_skip_op, skip_cond, ex_tbl_cur, ex_tbl_last} = c;
    imm_tgt = imm; pcl_wdata = wd; tbl_ptr = ptr; rom_word = word;
    #2;
  endtask

  task automatic addr_chk(input string req, input int exp_addr, input int exp_fl, input int exp_sv);
    chk(req, "rom_addr", int'(rom_addr), exp_addr);
    chk(req, "flush", int'(flush), exp_fl);
    chk(req, "slot_vld", int'(slot_vld), exp_sv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {ex_jmp, ex_call, ex_ret, ex_pcl_wr, ex_skip_op, skip_cond, ex_tbl_cur, ex_tbl_last} = '0;
    #2;
    // R1 state during reset
    chk("R1", "rom_addr", int'(rom_addr), 0);
    chk("R1", "flush", int'(flush), 0);
    chk("R1", "slot_vld", int'(slot_vld), 1);
    chk("R1", "rom_is_tbl", int'(rom_is_tbl), 0);
    chk("R1", "tbl_hi", int'(tbl_hi), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    {ex_jmp, ex_call, ex_ret, ex_pcl_wr, ex_skip_op, skip_cond, ex_tbl_cur, ex_tbl_last} = '0;
    imm_tgt = '0; pcl_wdata = '0; tbl_ptr = '0; rom_word = '0;
    rst_n = 1'b0;
    #5;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string rq;
      v = VEC[i];
      drive(v[41:34], v[33:24], v[23:16], 8'h00, 14'h0000);
      rq = $sformatf("R%0d", v[3:0]);
      addr_chk(rq, int'(v[15:6]), int'(v[5]), int'(v[4]));
    end

    // R9 current-page lookup issued at 0F2
    drive(C_TC, 10'h0, 8'h0, 8'h34, 14'h0000);
    addr_chk("R9", 'h0F2, 0, 1);
    chk("R9", "rom_is_tbl", int'(rom_is_tbl), 0);
    drive(C_N, 10'h0, 8'h0, 8'h34, 14'h2A5C);
    chk("R9", "rom_addr", int'(rom_addr), 'h034);
    chk("R9", "rom_is_tbl", int'(rom_is_tbl), 1);
    chk("R9", "slot_vld", int'(slot_vld), 0);
    chk("R9", "flush", int'(flush), 0);
    chk("R10", "tbl_lo", int'(tbl_lo), 'h5C);
    chk("R10", "tbl_lo_vld", int'(tbl_lo_vld), 1);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h3FFF);
    addr_chk("R9", 'h0F3, 0, 1);
    chk("R10", "tbl_hi", int'(tbl_hi), 'h2A);
    chk("R10", "tbl_lo_vld", int'(tbl_lo_vld), 0);

    // R9 last-page lookup issued at 0F4
    drive(C_TL, 10'h0, 8'h0, 8'h80, 14'h0000);
    addr_chk("R9", 'h0F4, 0, 1);
    drive(C_N, 10'h0, 8'h0, 8'h80, 14'h1234);
    chk("R9", "rom_addr last page", int'(rom_addr), 'h380);
    chk("R10", "tbl_hi before load", int'(tbl_hi), 'h2A);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R9", 'h0F5, 0, 1);
    chk("R10", "tbl_hi", int'(tbl_hi), 'h12);

    // R3 readable low byte
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    chk("R3", "pcl_rdata", int'(pcl_rdata), 'hF6);

    // R5 second call overwrites the entry; R6 entry survives a return
    drive(C_C, 10'h050, 8'h0, 8'h00, 14'h0000);
    addr_chk("R5", 'h0F7, 1, 1);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R5", 'h050, 0, 0);
    drive(C_C, 10'h060, 8'h0, 8'h00, 14'h0000);
    addr_chk("R5", 'h051, 1, 1);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    drive(C_R, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R6", 'h061, 1, 1);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R5", 'h051, 0, 0);
    drive(C_R, 10'h0, 8'h0, 8'h00, 14'h0000);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R6", 'h051, 0, 0);
    chk("R10", "tbl_hi held", int'(tbl_hi), 'h12);

    // R1 mid-run reset, then R6 return with no call
    do_reset();
    drive(C_R, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R1", 'h000, 1, 1);
    drive(C_N, 10'h0, 8'h0, 8'h00, 14'h0000);
    addr_chk("R6", 'h000, 0, 0);
    // R11 taken skip beats table lookup
    drive(C_SK | C_SC | C_TC, 10'h0, 8'h0, 8'h40, 14'h0000);
    addr_chk("R11", 'h001, 1, 1);
    drive(C_N, 10'h0, 8'h0, 8'h40, 14'h0000);
    addr_chk("R11", 'h002, 0, 0);
    chk("R11", "rom_is_tbl", int'(rom_is_tbl), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule